// File: doc/BRIEF.md
# Thermal Code Window Comparator Interrupt

This block watches the stream of averaged temperature codes coming out of a sensor's conversion path and raises an interrupt when a code falls outside a programmable window. Software programs a lower and an upper 12-bit code limit, turns comparison on, and unmasks the interrupt. Each time the conversion path presents a finished result with its valid strobe, the code is tested against the window. A code outside the window latches a sticky compare flag, and the interrupt line follows that flag through its enable bit.

The flag stays set until software writes one to its clear bit, so a brief excursion outside the window is not lost if the temperature returns inside it. A window whose lower limit is not strictly below its upper limit is treated as invalid, and no comparison takes place while it is programmed. Registers are written over a simple write-only strobe bus with byte offsets. Each write takes effect on the clock edge that accepts it.

Top module: `thermal_window_irq`

## Requirements
- R1: After reset the compare enable, the interrupt enable and both limits are 0, the flag is clear, and `irq_o` is low.
- R2: On a cycle with `result_valid_i` high, compare enabled (bit 0 of offset 0x18), and lower limit (offset 0x1C) below upper limit (offset 0x20), a code strictly below the lower limit or strictly above the upper limit sets the flag at that clock edge.
- R3: A code equal to either limit, or lying between them, does not set the flag.
- R4: While the lower limit is greater than or equal to the upper limit, no result sets the flag, whatever its code.
- R5: The flag is not set while compare enable is 0, nor on a cycle without `result_valid_i`, even if `result_code_i` lies outside the window.
- R6: Once set, the flag stays set across later in-range results until it is cleared.
- R7: `irq_o` is high exactly when the flag is set and bit 1 of the interrupt enable register (offset 0x34) is 1. The flag latches while that bit is 0, and `irq_o` rises as soon as the bit is then written to 1.
- R8: Writing a value with bit 1 set to offset 0x38 clears the flag. A write there with bit 1 clear has no effect on the flag, and a write to offset 0x30 is ignored.
- R9: If a clear write and a flag-setting result fall in the same cycle, the flag ends set. A clear write that coincides with an in-range result clears the flag.
- R10: A register write in the same cycle as a result strobe does not affect that result. The comparison uses the limit and enable values held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_valid_i | input | 1 | One-cycle strobe marking a finished averaged conversion |
| result_code_i | input | CODE_W (12) | Averaged conversion code, qualified by `result_valid_i` |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | CODE_W (12) | Register write data |
| irq_o | output | 1 | Compare interrupt, equal to the flag gated by its enable |

## Verification
Two things can hit the flag in one clock: a result strobe that sets it and a software clear write that resets it. The bench drives both in the same cycle, first with an out-of-range code, where the flag must survive, and then with an in-range code, where the clear must win. It also drives limit and enable writes in the same cycle as a result strobe, and judges from `irq_o` in the following cycle that the comparison used the values held before that edge.

// File: rtl/win_cmp_pkg.sv
package win_cmp_pkg;
  localparam int unsigned REG_ADDR_W = 8;
  typedef logic [REG_ADDR_W-1:0] reg_addr_t;

  // Offsets decoded by software; kept fixed
  localparam reg_addr_t ADDR_CMP_CTRL = 8'h18;
  localparam reg_addr_t ADDR_LIM_LO   = 8'h1C;
  localparam reg_addr_t ADDR_LIM_HI   = 8'h20;
  localparam reg_addr_t ADDR_IRQ_EN   = 8'h34;
  localparam reg_addr_t ADDR_IRQ_CLR  = 8'h38;

  localparam int unsigned CMP_EN_BIT   = 0;
  localparam int unsigned CMP_FLAG_BIT = 1;
endpackage

// File: rtl/win_cmp_regs.sv
module win_cmp_regs
  import win_cmp_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_addr_t         addr_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic              cmp_en_o,
  output logic              irq_en_o,
  output logic [CODE_W-1:0] lim_lo_o,
  output logic [CODE_W-1:0] lim_hi_o,
  output logic              clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_en_o <= 1'b0;
      irq_en_o <= 1'b0;
      lim_lo_o <= '0;
      lim_hi_o <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        ADDR_CMP_CTRL: cmp_en_o <= wdata_i[CMP_EN_BIT];
        ADDR_IRQ_EN:   irq_en_o <= wdata_i[CMP_FLAG_BIT];
        ADDR_LIM_LO:   lim_lo_o <= wdata_i;
        ADDR_LIM_HI:   lim_hi_o <= wdata_i;
        default: ;
      endcase
    end
  end

  // W1C pulse, not stored
  assign clr_o = wr_i && (addr_i == ADDR_IRQ_CLR) && wdata_i[CMP_FLAG_BIT];
endmodule

// File: rtl/win_cmp_eval.sv
module win_cmp_eval #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              cmp_en_i,
  input  logic [CODE_W-1:0] lim_lo_i,
  input  logic [CODE_W-1:0] lim_hi_i,
  output logic              hit_o
);
  logic win_ok, below, above;

  always_comb begin
    win_ok = lim_lo_i < lim_hi_i;
    below  = code_i < lim_lo_i;
    above  = code_i > lim_hi_i;
    hit_o  = valid_i && cmp_en_i && win_ok && (below || above);
  end
endmodule

// File: rtl/win_cmp_flag.sv
module win_cmp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  // Set wins over clear so a coincident event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/thermal_window_irq.sv
module thermal_window_irq
  import win_cmp_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              result_valid_i,
  input  logic [CODE_W-1:0] result_code_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [CODE_W-1:0] reg_wdata_i,
  output logic              irq_o
);
  logic              cmp_en;
  logic              irq_en;
  logic [CODE_W-1:0] lim_lo;
  logic [CODE_W-1:0] lim_hi;
  logic              clr_req;
  logic              hit;
  logic              cmp_flag;

  win_cmp_regs #(.CODE_W(CODE_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .cmp_en_o (cmp_en),
    .irq_en_o (irq_en),
    .lim_lo_o (lim_lo),
    .lim_hi_o (lim_hi),
    .clr_o    (clr_req)
  );

  win_cmp_eval #(.CODE_W(CODE_W)) i_eval (
    .valid_i  (result_valid_i),
    .code_i   (result_code_i),
    .cmp_en_i (cmp_en),
    .lim_lo_i (lim_lo),
    .lim_hi_i (lim_hi),
    .hit_o    (hit)
  );

  win_cmp_flag i_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (hit),
    .clr_i    (clr_req),
    .irq_en_i (irq_en),
    .flag_o   (cmp_flag),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/win_cmp_chk.sv
module win_cmp_chk #(
  parameter int unsigned CODE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              result_valid_i,
  input logic [CODE_W-1:0] result_code_i,
  input logic              cmp_en,
  input logic [CODE_W-1:0] lim_lo,
  input logic [CODE_W-1:0] lim_hi,
  input logic              clr_req,
  input logic              cmp_flag
);
  logic live, oor;
  assign live = result_valid_i && cmp_en;
  assign oor  = live && (lim_lo < lim_hi) &&
                ((result_code_i < lim_lo) || (result_code_i > lim_hi));

  assert_set_outside_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor |=> cmp_flag);

  assert_inside_no_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_flag && live && (lim_lo < lim_hi) &&
     (result_code_i >= lim_lo) && (result_code_i <= lim_hi)) |=> !cmp_flag);

  assert_bad_window_no_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_flag && (lim_lo >= lim_hi)) |=> !cmp_flag);

  assert_idle_no_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_flag && !live) |=> !cmp_flag);

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_flag && !clr_req) |=> cmp_flag);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !oor) |=> !cmp_flag);
endmodule

bind thermal_window_irq win_cmp_chk #(.CODE_W(CODE_W)) i_win_cmp_chk (.*);

// File: tb/test_thermal_window_irq.sv
module test_thermal_window_irq;
  localparam int CODE_W = 12;
  localparam logic [7:0] A_CTRL = 8'h18, A_LO = 8'h1C, A_HI = 8'h20,
                         A_STAT = 8'h30, A_IE = 8'h34, A_CLR = 8'h38;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              result_valid_i = 1'b0;
  logic [CODE_W-1:0] result_code_i = '0;
  logic              reg_wr_i = 1'b0;
  logic [7:0]        reg_addr_i = '0;
  logic [CODE_W-1:0] reg_wdata_i = '0;
  logic              irq_o;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk_i = ~clk_i;

  thermal_window_irq #(.CODE_W(CODE_W)) i_thermal_window_irq (
    .clk_i, .rst_ni, .result_valid_i, .result_code_i,
    .reg_wr_i, .reg_addr_i, .reg_wdata_i, .irq_o
  );

  // Monitor: compare irq_o one half period after the edge
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      n_vec++;
      if (irq_o !== it.exp) begin
        n_err++;
        $display("FAIL %s: irq_o=%0b expected %0b", it.tag, irq_o, it.exp);
      end
    end
  end

  task automatic cyc(input logic v, input logic [CODE_W-1:0] code,
                     input logic wr, input logic [7:0] addr,
                     input logic [CODE_W-1:0] data,
                     input logic exp, input string tag);
    @(negedge clk_i);
    #1;
    result_valid_i = v;
    result_code_i  = code;
    reg_wr_i       = wr;
    reg_addr_i     = addr;
    reg_wdata_i    = data;
    @(posedge clk_i);
    #1;
    result_valid_i = 1'b0;
    reg_wr_i       = 1'b0;
    sb_q.push_back('{exp, tag});
  endtask

  task automatic wr(input logic [7:0] addr, input logic [CODE_W-1:0] data,
                    input logic exp, input string tag);
    cyc(1'b0, '0, 1'b1, addr, data, exp, tag);
  endtask

  task automatic res(input logic [CODE_W-1:0] code, input logic exp, input string tag);
    cyc(1'b1, code, 1'b0, '0, '0, exp, tag);
  endtask

  task automatic check_reset_low();
    @(negedge clk_i);
    n_vec++;
    if (irq_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1: irq_o=%0b expected 0 in reset", irq_o);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    check_reset_low();
    #1 rst_ni = 1'b1;

    res(12'h000, 1'b0, "R1");           // reset limits/enable: nothing fires
    wr(A_IE, 12'h002, 1'b0, "R7");
    res(12'h000, 1'b0, "R5");           // compare disabled
    wr(A_LO, 12'h100, 1'b0, "R1");
    wr(A_HI, 12'h300, 1'b0, "R1");
    res(12'h050, 1'b0, "R5");
    wr(A_CTRL, 12'h001, 1'b0, "R5");
    cyc(1'b0, 12'h000, 1'b0, '0, '0, 1'b0, "R5"); // no strobe
    res(12'h100, 1'b0, "R3");
    res(12'h300, 1'b0, "R3");
    res(12'h200, 1'b0, "R3");
    res(12'h0FF, 1'b1, "R2");           // below
    res(12'h200, 1'b1, "R6");
    wr(A_CLR, 12'h001, 1'b1, "R8");     // bit 1 clear: no effect
    wr(A_STAT, 12'h000, 1'b1, "R8");    // status write ignored
    wr(A_CLR, 12'h002, 1'b0, "R8");
    res(12'h301, 1'b1, "R2");           // above
    wr(A_IE, 12'h000, 1'b0, "R7");
    wr(A_IE, 12'h002, 1'b1, "R7");
    wr(A_CLR, 12'h002, 1'b0, "R8");
    wr(A_IE, 12'h000, 1'b0, "R7");
    res(12'hFFF, 1'b0, "R7");           // latched but masked
    wr(A_IE, 12'h002, 1'b1, "R7");
    wr(A_CLR, 12'h002, 1'b0, "R8");

    wr(A_HI, 12'h100, 1'b0, "R4");      // lo == hi
    res(12'h000, 1'b0, "R4");
    res(12'hFFF, 1'b0, "R4");
    wr(A_HI, 12'h080, 1'b0, "R4");      // lo > hi
    res(12'h000, 1'b0, "R4");
    res(12'hFFF, 1'b0, "R4");
    wr(A_HI, 12'h300, 1'b0, "R4");

    cyc(1'b1, 12'h000, 1'b1, A_CLR, 12'h002, 1'b1, "R9"); // set beats clear
    cyc(1'b1, 12'h200, 1'b1, A_CLR, 12'h002, 1'b0, "R9"); // in range: clear wins

    cyc(1'b1, 12'h050, 1'b1, A_LO, 12'h020, 1'b1, "R10"); // old lo 0x100 used
    wr(A_CLR, 12'h002, 1'b0, "R10");
    res(12'h050, 1'b0, "R10");          // new lo 0x020 now in effect
    cyc(1'b1, 12'h010, 1'b1, A_CTRL, 12'h000, 1'b1, "R10"); // old enable used
    wr(A_CLR, 12'h002, 1'b0, "R10");
    res(12'h010, 1'b0, "R5");           // now disabled
    wr(A_CTRL, 12'h001, 1'b0, "R5");
    res(12'h010, 1'b1, "R2");

    // Reset mid-run clears flag and registers
    repeat (2) @(negedge clk_i);
    #1 rst_ni = 1'b0;
    check_reset_low();
    #1 rst_ni = 1'b1;
    wr(A_IE, 12'h002, 1'b0, "R1");
    res(12'h000, 1'b0, "R1");           // compare enable back to 0

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule